// File: doc/BRIEF.md
# Peripheral Lane Contention Recovery Controller

This block supervises one lane of a serial link on the peripheral side. The lane has two modes: a high-speed receive mode and a low-power signalling mode, in which the peripheral may also drive the lines. The block keeps the lane's mode state and runs two watchdog counters. The high-speed receive watchdog limits how long the receiver can stay in high-speed mode without seeing end-of-transmission. The low-power transmit watchdog limits how long the peripheral can hold the bus while it is driving.

When either watchdog expires, the lane is forced back to low-power receive. From then on it ignores every request and all bus activity until both sensed lines read high, which is the Stop state. When the Stop state is seen, the block reports a recovery error and the lane is idle again. Both counters run on a free-running local clock, so they keep counting even if the link clock stops.

While the lane drives in low-power transmit on a bidirectional link, the block also compares the level it drives on each line with the sensed level of that line. It flags a high fault when a line it drives high reads low, and a low fault when a line it drives low reads high. The sensed levels arrive without a clock and pass through a synchronizer. The drive levels and the enable are delayed by the same number of stages, so that the two sides are compared in the same cycle.

Top module: `lane_recovery_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the lane in idle low-power receive (`lane_mode` = 0), clears both counters and drives all pulse outputs and `lp_rx_forced` low.
- R2: In idle (`lane_mode` 0), `hs_req` moves the lane to high-speed receive (`lane_mode` 1) on the next edge, and `tx_req` moves it to low-power transmit (`lane_mode` 2). If both are high in the same cycle, `hs_req` wins.
- R3: Suppose high-speed receive is entered at edge E and no `eot` follows. Then `hrx_timeout` is a one-cycle pulse registered at edge E+`hrx_limit`+1, and at that same edge the lane enters the wait-for-Stop state (`lane_mode` 3).
- R4: An `eot` seen in high-speed receive returns the lane to idle with no error. This holds even when the `eot` falls in the same cycle as the expiry, because `eot` wins; an `eot` one cycle later is ignored.
- R5: Suppose low-power transmit is entered at edge E and `tx_req` stays high. Then `ltx_timeout` pulses at edge E+`ltx_limit`+1 and the lane enters wait-for-Stop. Dropping `tx_req` returns the lane to idle, and a drop in the expiry cycle wins.
- R6: In wait-for-Stop, `lp_rx_forced` is high, and `hs_req`, `tx_req` and `eot` have no effect. The lane stays in `lane_mode` 3 until the synchronized sense bus reads all ones (Stop).
- R7: The edge that sees Stop in wait-for-Stop returns the lane to idle, lowers `lp_rx_forced` and pulses `recov_err` for one cycle. A sense change reaches that edge after SYNC_STAGES edges.
- R8: In low-power transmit with `bidir` high, a line whose `drv_lvl` bit is 1 while its `sns_lvl` bit is 0 gives a one-cycle `lp_high_fault` pulse. The pulse comes two edges after the sense change, and there is one pulse for each onset of the mismatch.
- R9: Under the same conditions, a line whose `drv_lvl` bit is 0 while its `sns_lvl` bit is 1 gives a one-cycle `lp_low_fault` pulse on each onset. A high fault on one line and a low fault on another can pulse in the same cycle.
- R10: No contention fault is flagged when `bidir` is low, or when the lane is not in low-power transmit.
- R11: Each counter is cleared whenever the lane is outside its monitored mode. Re-entering a mode therefore restarts the full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous active-high reset |
| bidir | input | 1 | Lane is bidirectional; enables fault checking |
| hs_req | input | 1 | Start of a high-speed receive burst |
| eot | input | 1 | End-of-transmission seen by the receiver |
| tx_req | input | 1 | Peripheral wants or holds the bus in low-power transmit |
| hrx_limit | input | CNT_W | High-speed receive timeout limit in cycles |
| ltx_limit | input | CNT_W | Low-power transmit timeout limit in cycles |
| drv_lvl | input | LINES | Level driven on each line in low-power transmit |
| sns_lvl | input | LINES | Asynchronous sensed level of each line |
| lane_mode | output | 2 | 0 idle receive, 1 high-speed receive, 2 low-power transmit, 3 wait-for-Stop |
| lp_rx_forced | output | 1 | High while the lane waits for Stop after a timeout |
| hrx_timeout | output | 1 | One-cycle pulse on high-speed receive expiry |
| ltx_timeout | output | 1 | One-cycle pulse on low-power transmit expiry |
| recov_err | output | 1 | One-cycle pulse when Stop ends a forced recovery |
| lp_high_fault | output | 1 | One-cycle pulse on onset of a high contention fault |
| lp_low_fault | output | 1 | One-cycle pulse on onset of a low contention fault |

## Verification
Two events can fall in the same cycle: the `eot` that ends a burst and the expiry of the high-speed receive counter. The bench drives `eot` exactly in the cycle where the counter has reached its limit, and requires the lane to return to idle with no `hrx_timeout` pulse. It then drives `eot` one cycle later and requires the timeout, the wait state, and the `eot` to be ignored. The same is done for a `tx_req` drop against the transmit expiry. It also drives a high mismatch on one line and a low mismatch on the other at once, and expects both fault pulses in the same cycle. A scoreboard compares every output pulse against the cycle it predicts.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [1:0] {
    M_LP_RX     = 2'd0,
    M_HS_RX     = 2'd1,
    M_LP_TX     = 2'd2,
    M_WAIT_STOP = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/lrc_sync.sv
// Shift-register synchronizer / delay line, STAGES deep (STAGES >= 2).
module lrc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lrc_watchdog.sv
// Saturating cycle counter held at zero while clr is high.
module lrc_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (run && !hit)  cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);

  // R11: leaving the monitored mode leaves the counter at zero
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/lrc_contention.sv
// Drive-versus-sense comparison per line, with onset pulses.
module lrc_contention #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_en,
  input  logic [LINES-1:0] drv_lvl,
  input  logic [LINES-1:0] sns_s,
  output logic             high_pulse,
  output logic             low_pulse
);
  logic [LINES:0]   dly_q;
  logic             en_d;
  logic [LINES-1:0] drv_d;
  logic [LINES-1:0] hi_line, lo_line;
  logic             hi_cond, lo_cond, hi_q, lo_q;

  // align drive side with the synchronized sense side
  lrc_sync #(.W(LINES+1), .STAGES(STAGES), .RST_VAL('0)) u_dly (
    .clk(clk), .rst(rst), .d({chk_en, drv_lvl}), .q(dly_q)
  );
  assign en_d  = dly_q[LINES];
  assign drv_d = dly_q[LINES-1:0];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hi_line[g] = en_d &  drv_d[g] & ~sns_s[g];
    assign lo_line[g] = en_d & ~drv_d[g] &  sns_s[g];
  end

  assign hi_cond = |hi_line;
  assign lo_cond = |lo_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0; lo_q <= 1'b0;
      high_pulse <= 1'b0; low_pulse <= 1'b0;
    end else begin
      hi_q <= hi_cond;
      lo_q <= lo_cond;
      high_pulse <= hi_cond & ~hi_q;
      low_pulse  <= lo_cond & ~lo_q;
    end
  end

  // R8: a high fault is a single-cycle pulse per onset
  p_high_single_r8: assert property (@(posedge clk) disable iff (rst)
    high_pulse |=> !high_pulse);
  // R9: a low fault is a single-cycle pulse per onset
  p_low_single_r9: assert property (@(posedge clk) disable iff (rst)
    low_pulse |=> !low_pulse);
  // R10: no fault reported without an aligned enable
  p_gated_r10: assert property (@(posedge clk) disable iff (rst)
    !en_d |=> (!high_pulse && !low_pulse));
endmodule

// File: rtl/lane_recovery_ctrl.sv
module lane_recovery_ctrl
  import lrc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bidir,
  input  logic             hs_req,
  input  logic             eot,
  input  logic             tx_req,
  input  logic [CNT_W-1:0] hrx_limit,
  input  logic [CNT_W-1:0] ltx_limit,
  input  logic [LINES-1:0] drv_lvl,
  input  logic [LINES-1:0] sns_lvl,
  output logic [1:0]       lane_mode,
  output logic             lp_rx_forced,
  output logic             hrx_timeout,
  output logic             ltx_timeout,
  output logic             recov_err,
  output logic             lp_high_fault,
  output logic             lp_low_fault
);
  lane_mode_e       state, nxt;
  logic [LINES-1:0] sns_s;
  logic             stop_seen;
  logic             hrx_hit, ltx_hit;
  logic             hrx_n, ltx_n, err_n;

  lrc_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sns (
    .clk(clk), .rst(rst), .d(sns_lvl), .q(sns_s)
  );
  assign stop_seen = &sns_s;

  lrc_watchdog #(.CNT_W(CNT_W)) u_hrx_wd (
    .clk(clk), .rst(rst), .clr(state != M_HS_RX), .run(state == M_HS_RX),
    .limit(hrx_limit), .hit(hrx_hit)
  );

  lrc_watchdog #(.CNT_W(CNT_W)) u_ltx_wd (
    .clk(clk), .rst(rst), .clr(state != M_LP_TX), .run(state == M_LP_TX),
    .limit(ltx_limit), .hit(ltx_hit)
  );

  lrc_contention #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_cont (
    .clk(clk), .rst(rst), .chk_en(bidir && (state == M_LP_TX)),
    .drv_lvl(drv_lvl), .sns_s(sns_s),
    .high_pulse(lp_high_fault), .low_pulse(lp_low_fault)
  );

  always_comb begin
    nxt   = state;
    hrx_n = 1'b0;
    ltx_n = 1'b0;
    err_n = 1'b0;
    unique case (state)
      M_LP_RX: begin
        if (hs_req)      nxt = M_HS_RX;
        else if (tx_req) nxt = M_LP_TX;
      end
      M_HS_RX: begin
        if (eot) nxt = M_LP_RX;
        else if (hrx_hit) begin
          nxt   = M_WAIT_STOP;
          hrx_n = 1'b1;
        end
      end
      M_LP_TX: begin
        if (!tx_req) nxt = M_LP_RX;
        else if (ltx_hit) begin
          nxt   = M_WAIT_STOP;
          ltx_n = 1'b1;
        end
      end
      M_WAIT_STOP: begin
        if (stop_seen) begin
          nxt   = M_LP_RX;
          err_n = 1'b1;
        end
      end
      default: nxt = M_LP_RX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= M_LP_RX;
      lp_rx_forced <= 1'b0;
      hrx_timeout  <= 1'b0;
      ltx_timeout  <= 1'b0;
      recov_err    <= 1'b0;
    end else begin
      state        <= nxt;
      lp_rx_forced <= (nxt == M_WAIT_STOP);
      hrx_timeout  <= hrx_n;
      ltx_timeout  <= ltx_n;
      recov_err    <= err_n;
    end
  end

  assign lane_mode = state;

  // R4: end-of-transmission beats the expiry
  p_eot_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (state == M_HS_RX && eot) |=> (state == M_LP_RX && !hrx_timeout));
  // R3: an expiry pulse comes with the forced wait
  p_hrx_forces_r3: assert property (@(posedge clk) disable iff (rst)
    hrx_timeout |-> (lp_rx_forced && state == M_WAIT_STOP));
  // R5: a drop of the transmit request beats the expiry
  p_drop_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (state == M_LP_TX && !tx_req) |=> (state == M_LP_RX && !ltx_timeout));
  // R6: wait-for-Stop is left only through Stop
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == M_WAIT_STOP && !stop_seen) |=> (state == M_WAIT_STOP && lp_rx_forced));
  // R7: Stop ends the recovery with an error pulse
  p_stop_err_r7: assert property (@(posedge clk) disable iff (rst)
    (state == M_WAIT_STOP && stop_seen) |=> (recov_err && !lp_rx_forced));
  // R3/R5/R7: timeout and recovery pulses never coincide
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hrx_timeout, ltx_timeout, recov_err}));
endmodule

// File: tb/tb_lane_recovery_ctrl.sv
module tb_lane_recovery_ctrl;
  localparam int HL = 5;
  localparam int LL = 4;
  localparam logic [4:0] EV_HRX = 5'b10000;
  localparam logic [4:0] EV_LTX = 5'b01000;
  localparam logic [4:0] EV_ERR = 5'b00100;
  localparam logic [4:0] EV_HI  = 5'b00010;
  localparam logic [4:0] EV_LO  = 5'b00001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bidir = 1'b0, hs_req = 1'b0, eot = 1'b0, tx_req = 1'b0;
  logic [15:0] hrx_limit = 16'(HL);
  logic [15:0] ltx_limit = 16'(LL);
  logic [1:0] drv_lvl = 2'b11;
  logic [1:0] sns_lvl = 2'b00;
  logic [1:0] lane_mode;
  logic lp_rx_forced, hrx_timeout, ltx_timeout, recov_err, lp_high_fault, lp_low_fault;

  lane_recovery_ctrl dut (
    .clk(clk), .rst(rst), .bidir(bidir), .hs_req(hs_req), .eot(eot), .tx_req(tx_req),
    .hrx_limit(hrx_limit), .ltx_limit(ltx_limit), .drv_lvl(drv_lvl), .sns_lvl(sns_lvl),
    .lane_mode(lane_mode), .lp_rx_forced(lp_rx_forced), .hrx_timeout(hrx_timeout),
    .ltx_timeout(ltx_timeout), .recov_err(recov_err), .lp_high_fault(lp_high_fault),
    .lp_low_fault(lp_low_fault)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         at;
    logic [4:0] ev;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: compares every output pulse with the scoreboard
  always @(negedge clk) begin
    logic [4:0] v;
    v = {hrx_timeout, ltx_timeout, recov_err, lp_high_fault, lp_low_fault};
    if (q.size() > 0 && q[0].at == cyc) begin
      checks++;
      if (v !== q[0].ev) begin
        errors++;
        $display("FAIL %s cycle %0d pulses=%b expected=%b", q[0].tag, cyc, v, q[0].ev);
      end
      void'(q.pop_front());
    end else if (v !== 5'b0) begin
      checks++;
      errors++;
      $display("FAIL unexpected pulse (R3/R5/R7/R8/R9/R10) cycle %0d pulses=%b expected=00000", cyc, v);
    end
    cyc++;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic go(int t);
    while (cyc < t) step();
  endtask

  task automatic expect_ev(int at, logic [4:0] ev, string tag);
    q.push_back('{at: at, ev: ev, tag: tag});
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic recover(string tag);
    int s;
    s = cyc;
    sns_lvl = 2'b11;
    expect_ev(s + 2, EV_ERR, tag);
    go(s + 3);
    chk(lane_mode == 2'd0, {tag, " mode idle"}, lane_mode, 0);
    chk(lp_rx_forced == 1'b0, {tag, " forced low"}, lp_rx_forced, 0);
    sns_lvl = 2'b00;
    repeat (3) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    int c2;
    int s;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(lane_mode == 2'd0, "R1 reset mode", lane_mode, 0);
    chk(lp_rx_forced == 1'b0, "R1 reset forced", lp_rx_forced, 0);

    // normal burst closed by eot
    c = cyc; hs_req = 1'b1; step(); hs_req = 1'b0;
    chk(lane_mode == 2'd1, "R2 enter HS", lane_mode, 1);
    go(c + 3); eot = 1'b1; step(); eot = 1'b0;
    chk(lane_mode == 2'd0, "R4 eot to idle", lane_mode, 0);

    // HS timeout, activity ignored, Stop recovery
    step();
    c = cyc; hs_req = 1'b1; expect_ev(c + HL + 1, EV_HRX, "R3 hrx expiry");
    step(); hs_req = 1'b0;
    go(c + HL + 2);
    chk(lane_mode == 2'd3, "R3 wait after expiry", lane_mode, 3);
    chk(lp_rx_forced == 1'b1, "R6 forced high", lp_rx_forced, 1);
    hs_req = 1'b1; tx_req = 1'b1; eot = 1'b1; step(); step();
    hs_req = 1'b0; tx_req = 1'b0; eot = 1'b0; step();
    chk(lane_mode == 2'd3, "R6 requests ignored", lane_mode, 3);
    recover("R7 stop after hrx");

    // eot exactly in the expiry cycle wins
    c = cyc; hs_req = 1'b1; step(); hs_req = 1'b0;
    go(c + HL + 1); eot = 1'b1; step(); eot = 1'b0;
    chk(lane_mode == 2'd0, "R4 eot on expiry cycle", lane_mode, 0);

    // eot one cycle late is ignored
    step();
    c = cyc; hs_req = 1'b1; expect_ev(c + HL + 1, EV_HRX, "R4 late eot expiry");
    step(); hs_req = 1'b0;
    go(c + HL + 2); eot = 1'b1; step(); eot = 1'b0;
    chk(lane_mode == 2'd3, "R6 late eot ignored", lane_mode, 3);
    recover("R7 stop after late eot");

    // LP transmit timeout, bidir low with a would-be low fault (R10)
    sns_lvl = 2'b11; drv_lvl = 2'b00; repeat (3) step();
    c = cyc; tx_req = 1'b1;
    expect_ev(c + LL + 1, EV_LTX, "R5 ltx expiry");
    expect_ev(c + LL + 2, EV_ERR, "R7 stop already present");
    step();
    chk(lane_mode == 2'd2, "R2 enter LP TX", lane_mode, 2);
    go(c + LL + 2); tx_req = 1'b0;
    chk(lane_mode == 2'd3, "R5 wait after ltx", lane_mode, 3);
    step();
    chk(lane_mode == 2'd0, "R7 idle after stop", lane_mode, 0);

    // tx_req drop in the expiry cycle wins
    step();
    c = cyc; tx_req = 1'b1; step();
    go(c + LL + 1); tx_req = 1'b0; step();
    chk(lane_mode == 2'd0, "R5 drop on expiry cycle", lane_mode, 0);

    // re-entry restarts the count
    sns_lvl = 2'b00; drv_lvl = 2'b11; repeat (3) step();
    c = cyc; hs_req = 1'b1; step(); hs_req = 1'b0;
    go(c + 3); eot = 1'b1; step(); eot = 1'b0;
    c2 = cyc; hs_req = 1'b1; expect_ev(c2 + HL + 1, EV_HRX, "R11 full restart");
    step(); hs_req = 1'b0;
    go(c2 + HL + 1);
    chk(lane_mode == 2'd1, "R11 still HS before restart limit", lane_mode, 1);
    step();
    chk(lane_mode == 2'd3, "R11 expiry after restart", lane_mode, 3);
    recover("R7 stop after restart");

    // priority of hs_req over tx_req
    hs_req = 1'b1; tx_req = 1'b1; step(); hs_req = 1'b0; tx_req = 1'b0;
    chk(lane_mode == 2'd1, "R2 hs_req priority", lane_mode, 1);
    eot = 1'b1; step(); eot = 1'b0; step();
    chk(lane_mode == 2'd0, "R4 idle after priority test", lane_mode, 0);

    // contention faults in LP transmit, bidirectional
    bidir = 1'b1; ltx_limit = 16'd60; sns_lvl = 2'b11; drv_lvl = 2'b11; repeat (3) step();
    c = cyc; tx_req = 1'b1; step();
    go(c + 2);
    s = cyc; sns_lvl = 2'b01; expect_ev(s + 2, EV_HI, "R8 high fault line1");
    go(s + 4); sns_lvl = 2'b11; go(s + 7);
    s = cyc; drv_lvl = 2'b00; expect_ev(s + 2, EV_LO, "R9 low fault");
    go(s + 4); drv_lvl = 2'b11; go(s + 7);
    s = cyc; drv_lvl = 2'b01; sns_lvl = 2'b10;
    expect_ev(s + 2, EV_HI | EV_LO, "R8 R9 same-cycle faults");
    go(s + 4); drv_lvl = 2'b11; sns_lvl = 2'b11; go(s + 7);
    tx_req = 1'b0; step();
    chk(lane_mode == 2'd0, "R5 idle after contention test", lane_mode, 0);

    // outside LP transmit no fault even when bidirectional
    repeat (4) step();
    drv_lvl = 2'b00;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(lp_low_fault == 1'b0, "R10 no fault outside LP TX", lp_low_fault, 0);
    end
    drv_lvl = 2'b11;

    // reset in the middle of a recovery
    sns_lvl = 2'b00; repeat (3) step();
    c = cyc; hs_req = 1'b1; expect_ev(c + HL + 1, EV_HRX, "R3 expiry before reset");
    step(); hs_req = 1'b0;
    go(c + HL + 3);
    chk(lane_mode == 2'd3, "R6 waiting before reset", lane_mode, 3);
    rst = 1'b1; step(); rst = 1'b0;
    chk(lane_mode == 2'd0, "R1 reset from wait", lane_mode, 0);
    chk(lp_rx_forced == 1'b0, "R1 reset clears forced", lp_rx_forced, 0);

    repeat (5) step();
    chk(q.size() == 0, "scoreboard drained (R3 R5 R7 R8 R9)", q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule